// File: doc/BRIEF.md
# Saturating Per-Page Update Counter Array

This block holds a small saturating counter for every page of a memory. Each write to a page bumps that page's counter. The counter stops climbing once it reaches its largest value, so a two-bit counter tells apart zero, one, two, and "three or more" updates. Two consumers use these values. The checkpoint engine reads a page's counter and clears it in the same request. A zero reading means the page has not changed since its last checkpoint and can be skipped. After a failure, the recovery engine loads stored counter values back in. For each value loaded, the block reports whether the page is hot, meaning its counter was saturated. Hot pages are reloaded at once and the rest are reloaded when first needed.

The counters sit in an on-chip register array indexed by page number, with one counter cell per page. Three ports can act in the same cycle:

- the update port;
- the checkpoint read-and-clear port;
- the recovery load port.

A fixed priority settles collisions on one page. When a checkpoint clear and an update hit the same page, the result is a count of one, so the new write is never lost.

Top module: `page_upd_counters`

## Requirements
- R1: While reset is asserted and after it is released, every counter reads 0, and both result-valid outputs are low until a request is made.
- R2: An update request on a page that is neither cleared nor loaded in the same cycle raises that page's counter by exactly one, unless the counter is already at its maximum.
- R3: A counter at its maximum value 2^CNT_W-1 (3 for the default width of 2) stays at that value on further updates and never wraps to 0.
- R4: A checkpoint request returns, one cycle later, the counter value the page held before that cycle. The dirty flag is 1 exactly when that value is nonzero. The page's counter becomes 0.
- R5: When an update and a checkpoint clear name the same page in the same cycle, that page's counter becomes 1.
- R6: The checkpoint result-valid output is high in exactly the cycle after a checkpoint request and low otherwise.
- R7: A recovery load writes the supplied value into the named page's counter. One cycle later the hot-valid output is high, and the hot flag is 1 exactly when the loaded value equals 2^CNT_W-1.
- R8: A recovery load to a page takes priority over an update and a checkpoint clear to that same page in the same cycle: the counter takes the loaded value.
- R9: Requests naming different pages in the same cycle act independently, each with its own effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_valid | input | 1 | Update request |
| upd_page | input | PG_W | Page written |
| ckpt_valid | input | 1 | Checkpoint read-and-clear request |
| ckpt_page | input | PG_W | Page to read and clear |
| rec_valid | input | 1 | Recovery load request |
| rec_page | input | PG_W | Page to load |
| rec_count | input | CNT_W | Counter value to load |
| ckpt_rd_valid | output | 1 | Checkpoint result valid |
| ckpt_rd_count | output | CNT_W | Counter value before the clear |
| ckpt_rd_dirty | output | 1 | Page changed since its last checkpoint |
| rec_hot_valid | output | 1 | Hot flag valid |
| rec_hot | output | 1 | Loaded value was saturated |

## Verification
A corrupted counter cell stays hidden until its page is read at a checkpoint. The wrong value then appears on the count and dirty outputs exactly one cycle after that request. For this reason the bench reads pages back often, and it keeps addresses in a narrow range for long stretches so that collisions between ports and saturation happen frequently. A fault in the priority between load, clear and update shows up at the next checkpoint of the affected page, as a count that differs from 0, 1 or the loaded value. A fault in the hot decode shows up on the cycle after the load itself.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [2:0] {
    CELL_HOLD,
    CELL_LOAD,
    CELL_ZERO,
    CELL_ONE,
    CELL_BUMP
  } cell_act_e;

  // Priority: recovery load, then checkpoint clear (keeping a same-cycle
  // update as a count of one), then a non-saturating increment.
  function automatic cell_act_e pick_act(input logic ld, input logic clr,
                                         input logic inc, input logic at_top);
    if (ld)                 return CELL_LOAD;
    else if (clr && inc)    return CELL_ONE;
    else if (clr)           return CELL_ZERO;
    else if (inc && !at_top) return CELL_BUMP;
    else                    return CELL_HOLD;
  endfunction

endpackage

// File: rtl/pgc_decode.sv
module pgc_decode #(
  parameter int PAGES = 64,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic             en,
  input  logic [PG_W-1:0]  idx,
  output logic [PAGES-1:0] sel
);

  for (genvar g = 0; g < PAGES; g++) begin : g_dec
    assign sel[g] = en && (idx == PG_W'(g));
  end

endmodule

// File: rtl/pgc_cell.sv
module pgc_cell
  import pgc_pkg::*;
#(
  parameter int CNT_W = 2,
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);

  cell_act_e        act;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    act     = pick_act(ld, clr, inc, cnt == TOP);
    cnt_en  = (act != CELL_HOLD);
    cnt_nxt = cnt;
    case (act)
      CELL_LOAD: cnt_nxt = ld_val;
      CELL_ZERO: cnt_nxt = '0;
      CELL_ONE:  cnt_nxt = CNT_W'(1);
      CELL_BUMP: cnt_nxt = cnt + CNT_W'(1);
      default:   cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !clr && !ld) |=> (cnt == TOP));

  // R5
  clr_inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc && !ld) |=> (cnt == CNT_W'(1)));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld && cnt != TOP) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/pgc_readout.sv
module pgc_readout #(
  parameter int PAGES = 64,
  parameter int CNT_W = 2,
  localparam int PG_W = $clog2(PAGES),
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAGES*CNT_W-1:0] cnt_flat,
  input  logic                   ckpt_valid,
  input  logic [PG_W-1:0]        ckpt_page,
  input  logic                   rec_valid,
  input  logic [CNT_W-1:0]       rec_count,
  output logic                   ckpt_rd_valid,
  output logic [CNT_W-1:0]       ckpt_rd_count,
  output logic                   ckpt_rd_dirty,
  output logic                   rec_hot_valid,
  output logic                   rec_hot
);

  logic [CNT_W-1:0] sel_cnt;
  logic             hot_nxt;

  always_comb begin
    sel_cnt = cnt_flat[ckpt_page*CNT_W +: CNT_W];
    hot_nxt = (rec_count == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckpt_rd_valid <= 1'b0;
      rec_hot_valid <= 1'b0;
    end else begin
      ckpt_rd_valid <= ckpt_valid;
      rec_hot_valid <= rec_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckpt_rd_count <= '0;
      ckpt_rd_dirty <= 1'b0;
    end else if (ckpt_valid) begin
      ckpt_rd_count <= sel_cnt;
      ckpt_rd_dirty <= (sel_cnt != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rec_hot <= 1'b0;
    else if (rec_valid) rec_hot <= hot_nxt;
  end

  // R6
  ckpt_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_valid |=> ckpt_rd_valid);

  // R4
  dirty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_rd_valid |-> (ckpt_rd_dirty == (ckpt_rd_count != '0)));

endmodule

// File: rtl/page_upd_counters.sv
module page_upd_counters #(
  parameter int PAGES = 64,
  parameter int CNT_W = 2,
  localparam int PG_W = $clog2(PAGES),
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [PG_W-1:0]  upd_page,
  input  logic             ckpt_valid,
  input  logic [PG_W-1:0]  ckpt_page,
  input  logic             rec_valid,
  input  logic [PG_W-1:0]  rec_page,
  input  logic [CNT_W-1:0] rec_count,
  output logic             ckpt_rd_valid,
  output logic [CNT_W-1:0] ckpt_rd_count,
  output logic             ckpt_rd_dirty,
  output logic             rec_hot_valid,
  output logic             rec_hot
);

  logic [PAGES-1:0]       inc_sel;
  logic [PAGES-1:0]       clr_sel;
  logic [PAGES-1:0]       ld_sel;
  logic [PAGES*CNT_W-1:0] cnt_flat;

  pgc_decode #(.PAGES(PAGES)) u_dec_upd (
    .en(upd_valid), .idx(upd_page), .sel(inc_sel));
  pgc_decode #(.PAGES(PAGES)) u_dec_ckpt (
    .en(ckpt_valid), .idx(ckpt_page), .sel(clr_sel));
  pgc_decode #(.PAGES(PAGES)) u_dec_rec (
    .en(rec_valid), .idx(rec_page), .sel(ld_sel));

  for (genvar g = 0; g < PAGES; g++) begin : g_cell
    pgc_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_sel[g]),
      .clr    (clr_sel[g]),
      .ld     (ld_sel[g]),
      .ld_val (rec_count),
      .cnt    (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  pgc_readout #(.PAGES(PAGES), .CNT_W(CNT_W)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_flat      (cnt_flat),
    .ckpt_valid    (ckpt_valid),
    .ckpt_page     (ckpt_page),
    .rec_valid     (rec_valid),
    .rec_count     (rec_count),
    .ckpt_rd_valid (ckpt_rd_valid),
    .ckpt_rd_count (ckpt_rd_count),
    .ckpt_rd_dirty (ckpt_rd_dirty),
    .rec_hot_valid (rec_hot_valid),
    .rec_hot       (rec_hot)
  );

  // R7
  hot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (rec_hot_valid && (rec_hot == ($past(rec_count) == TOP))));

  // R4
  ckpt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_valid && !upd_valid && !rec_valid)
      |=> (cnt_flat[$past(ckpt_page)*CNT_W +: CNT_W] == '0));

endmodule

// File: tb/page_upd_counters_tb.sv
module page_upd_counters_tb_top;

  localparam int PAGES = 64;
  localparam int CNT_W = 2;
  localparam int PG_W  = 6;
  localparam int TOPV  = 3;

  logic             clk;
  logic             rst_n;
  logic             upd_valid;
  logic [PG_W-1:0]  upd_page;
  logic             ckpt_valid;
  logic [PG_W-1:0]  ckpt_page;
  logic             rec_valid;
  logic [PG_W-1:0]  rec_page;
  logic [CNT_W-1:0] rec_count;
  logic             ckpt_rd_valid;
  logic [CNT_W-1:0] ckpt_rd_count;
  logic             ckpt_rd_dirty;
  logic             rec_hot_valid;
  logic             rec_hot;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mdl [PAGES];

  page_upd_counters #(.PAGES(PAGES), .CNT_W(CNT_W)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int next_val(input int cur, input bit inc, input bit clr,
                                  input bit ld, input int ldv);
    if (ld) return ldv;
    if (clr) return inc ? 1 : 0;
    if (inc && cur < TOPV) return cur + 1;
    return cur;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking outputs.
  task automatic step(input bit uv, input int up, input bit cv, input int cp,
                      input bit rv, input int rp, input int rc, input string tag);
    int exp_cnt;
    bit exp_hot;
    upd_valid = uv; upd_page = PG_W'(up);
    ckpt_valid = cv; ckpt_page = PG_W'(cp);
    rec_valid = rv; rec_page = PG_W'(rp); rec_count = CNT_W'(rc);
    exp_cnt = mdl[cp];
    exp_hot = (rc == TOPV);
    for (int p = 0; p < PAGES; p++)
      mdl[p] = next_val(mdl[p], uv && up == p, cv && cp == p, rv && rp == p, rc);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 0; ckpt_valid = 0; rec_valid = 0;
    chk(ckpt_rd_valid == cv, {"R6 ", tag}, ckpt_rd_valid, cv);
    chk(rec_hot_valid == rv, {"R7 valid ", tag}, rec_hot_valid, rv);
    if (cv) begin
      chk(ckpt_rd_count == exp_cnt, {"R4 count ", tag}, ckpt_rd_count, exp_cnt);
      chk(ckpt_rd_dirty == (exp_cnt != 0), {"R4 dirty ", tag}, ckpt_rd_dirty, exp_cnt != 0);
    end
    if (rv) chk(rec_hot == exp_hot, {"R7 hot ", tag}, rec_hot, exp_hot);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, "idle"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < PAGES; p++) mdl[p] = 0;
    rst_n = 0; upd_valid = 0; upd_page = '0; ckpt_valid = 0; ckpt_page = '0;
    rec_valid = 0; rec_page = '0; rec_count = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    chk(ckpt_rd_valid == 0 && rec_hot_valid == 0, "R1 reset valids", ckpt_rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: every counter reads zero after reset
    for (int p = 0; p < PAGES; p++) step(0, 0, 1, p, 0, 0, 0, "R1 reset read");

    // R2 / R3: five updates saturate at 3
    for (int i = 0; i < 5; i++) step(1, 3, 0, 0, 0, 0, 0, "R3 bump");
    step(0, 0, 1, 3, 0, 0, 0, "R3 saturated read");
    step(0, 0, 1, 3, 0, 0, 0, "R4 read after clear");
    // R2: two updates read back as 2
    step(1, 9, 0, 0, 0, 0, 0, "R2 bump");
    step(1, 9, 0, 0, 0, 0, 0, "R2 bump");
    step(0, 0, 1, 9, 0, 0, 0, "R2 count two");
    // R5: clear and update same page
    step(1, 5, 0, 0, 0, 0, 0, "R5 pre");
    step(1, 5, 1, 5, 0, 0, 0, "R5 collide");
    step(0, 0, 1, 5, 0, 0, 0, "R5 leaves one");
    // R7: hot and not hot loads
    step(0, 0, 0, 0, 1, 20, 3, "R7 load hot");
    step(0, 0, 0, 0, 1, 21, 2, "R7 load cool");
    step(0, 0, 1, 20, 0, 0, 0, "R7 readback hot");
    step(0, 0, 1, 21, 0, 0, 0, "R7 readback cool");
    // R8: load beats update and clear
    step(1, 30, 1, 30, 1, 30, 2, "R8 triple");
    step(0, 0, 1, 30, 0, 0, 0, "R8 load kept");
    // R9: different pages at once
    step(1, 40, 1, 41, 1, 42, 1, "R9 split");
    step(0, 0, 1, 40, 0, 0, 0, "R9 upd page");
    step(0, 0, 1, 42, 0, 0, 0, "R9 load page");
    idle();

    // Random mix; narrow page range in first half to force collisions
    for (int i = 0; i < 4000; i++) begin
      int rng;
      rng = (i < 2000) ? 4 : PAGES;
      step($urandom % 4 != 0, $urandom % rng, $urandom % 3 == 0, $urandom % rng,
           $urandom % 8 == 0, $urandom % rng, $urandom % 4, "R9 random");
    end
    for (int p = 0; p < PAGES; p++) step(0, 0, 1, p, 0, 0, 0, "R4 final sweep");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule